// File: doc/BRIEF.md
# SDRAM Command and Address Decoder

This block is the device-side command front end of a four-bank, 16-bit synchronous DRAM. At every rising clock edge it samples the chip select, the three active-low command strobes (row strobe, column strobe and write enable), the two bank bits and the 12-bit address. It turns them into one registered, single-cycle strobe: activate, read, write or precharge. Each strobe carries the bank and the row or column address. Read and write also carry the auto-precharge flag, and precharge carries the all-banks flag. Unsupported codes and protocol violations are flagged instead of forwarded.

The block also keeps the state of every bank: whether it is open, which row it holds, and whether an auto-precharge is waiting. A waiting auto-precharge closes its bank when the external burst-done input for that bank is sampled high. This happens whether or not the decoder is taking commands, so work already under way still completes while chip select is high or the clock enable is low.

The outputs are single-cycle strobes with no valid/ready handshake. The block applies no back-pressure, and a consumer cannot stall it. Any unit downstream has to accept each strobe in the cycle it appears.

Top module: `sdram_cmd_front`

## Requirements
- R1: While reset is asserted, all strobes and fields are zero, no bank is open and every stored row reads zero.
- R2: Activate is {ras_n,cas_n,we_n}=011. When the addressed bank is closed, act_o pulses in the cycle after the sampling edge with bank_o = bank bits and row_o = all 12 address bits. The bank becomes open, and its row appears in rows_o[12*b+11:12*b].
- R3: Read is 101 and write is 100. When the addressed bank is open, rd_o or wr_o pulses with col_o = {A11, A9..A0}, with A11 in col_o bit 10. auto_pre_o equals A10, and A10 is not part of the column.
- R4: Precharge is 010. With A10 low it closes only the bank named by the bank bits, and pre_all_o is 0.
- R5: Precharge with A10 high closes every bank, whatever the bank bits are, and sets pre_all_o to 1.
- R6: When chip select is high at an edge, the command is ignored: no strobe and no change to bank state. A waiting auto-precharge still completes on burst-done.
- R7: When cke_i is sampled low at an edge, the command at that edge is ignored in the same way.
- R8: The codes 000, 001 and 110, sampled while the block is selected and enabled, give a one-cycle unsup_o pulse and no other strobe. The code 111 is a no-operation.
- R9: A read or write to a closed bank is not forwarded, and proto_err_o pulses instead.
- R10: An activate to an open bank is not forwarded. proto_err_o pulses, and the stored row is unchanged.
- R11: A read or write with A10 high arms auto-precharge for its bank. The bank closes at the edge where burst_done_i for that bank is sampled high. burst_done_i has no effect on a bank with nothing armed. A precharge or activate of the bank disarms it.
- R12: At most one of act_o, rd_o, wr_o, pre_o, unsup_o and proto_err_o is high in any cycle. Fields are zero when no command is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable; low freezes command sampling |
| csn_i | input | 1 | Chip select, active low |
| rasn_i | input | 1 | Row strobe, active low |
| casn_i | input | 1 | Column strobe, active low |
| wen_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Multiplexed address; bit 10 is the overloaded flag |
| burst_done_i | input | 4 | Per-bank burst-complete indication |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pre_o | output | 1 | Precharge strobe |
| unsup_o | output | 1 | Unsupported-command pulse |
| proto_err_o | output | 1 | Protocol-error pulse |
| bank_o | output | 2 | Bank of the forwarded command |
| row_o | output | 12 | Row address of an activate |
| col_o | output | 11 | Column address of a read or write |
| auto_pre_o | output | 1 | Auto-precharge request of a read or write |
| pre_all_o | output | 1 | Precharge applies to all banks |
| open_o | output | 4 | Per-bank open state |
| rows_o | output | 48 | Stored open row per bank, bank b at bits 12b+11..12b |

## Verification
Every strobe, field and bank-state change is due exactly one clock after the edge that samples the command or burst-done input. The bench therefore drives each command at a falling edge and compares all outputs at the next falling edge, half a cycle after the registers update. Expected values come from a bench model of the bank states, which it updates once for each issued command. Because each sample covers a single sampling edge, an ignored command (R6, R7) is detected by the absence of strobes and by an unchanged open_o and rows_o at that same sample.

// File: rtl/sdram_fe_pkg.sv
package sdram_fe_pkg;
  typedef enum logic [2:0] {
    K_IDLE  = 3'd0,
    K_ACT   = 3'd1,
    K_RD    = 3'd2,
    K_WR    = 3'd3,
    K_PRE   = 3'd4,
    K_UNSUP = 3'd5
  } cmd_kind_e;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] PIN_ACT = 3'b011;
  localparam logic [2:0] PIN_RD  = 3'b101;
  localparam logic [2:0] PIN_WR  = 3'b100;
  localparam logic [2:0] PIN_PRE = 3'b010;
  localparam logic [2:0] PIN_NOP = 3'b111;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_fe_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10
) (
  input  logic              cke_i,
  input  logic              csn_i,
  input  logic              rasn_i,
  input  logic              casn_i,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_kind_e         kind_o,
  output logic [ADDR_W-2:0] col_o,
  output logic              flag_o
);
  always_comb begin
    kind_o = K_IDLE;
    if (cke_i && !csn_i) begin
      unique case ({rasn_i, casn_i, wen_i})
        PIN_ACT: kind_o = K_ACT;
        PIN_RD:  kind_o = K_RD;
        PIN_WR:  kind_o = K_WR;
        PIN_PRE: kind_o = K_PRE;
        PIN_NOP: kind_o = K_IDLE;
        default: kind_o = K_UNSUP;
      endcase
    end
  end

  // The overloaded bit is removed from the column and reported separately.
  assign col_o  = {addr_i[ADDR_W-1:AP_BIT+1], addr_i[AP_BIT-1:0]};
  assign flag_o = addr_i[AP_BIT];
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_hit_i,
  input  logic             rw_hit_i,
  input  logic             ap_i,
  input  logic             pre_hit_i,
  input  logic             done_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);
  logic armed_q;
  logic auto_close;

  assign auto_close = done_i && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o  <= 1'b0;
      row_o   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (act_hit_i) begin
        open_o <= 1'b1;
        row_o  <= row_i;
      end else if (pre_hit_i || auto_close) begin
        open_o <= 1'b0;
      end

      if (pre_hit_i || act_hit_i) armed_q <= 1'b0;
      else if (rw_hit_i)          armed_q <= ap_i;
      else if (auto_close)        armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_fe_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int COL_W    = ADDR_W - 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cke_i,
  input  logic                        csn_i,
  input  logic                        rasn_i,
  input  logic                        casn_i,
  input  logic                        wen_i,
  input  logic [BA_W-1:0]             ba_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_BANKS-1:0]        burst_done_i,
  output logic                        act_o,
  output logic                        rd_o,
  output logic                        wr_o,
  output logic                        pre_o,
  output logic                        unsup_o,
  output logic                        proto_err_o,
  output logic [BA_W-1:0]             bank_o,
  output logic [ADDR_W-1:0]           row_o,
  output logic [COL_W-1:0]            col_o,
  output logic                        auto_pre_o,
  output logic                        pre_all_o,
  output logic [NUM_BANKS-1:0]        open_o,
  output logic [NUM_BANKS*ADDR_W-1:0] rows_o
);
  cmd_kind_e         kind;
  logic [COL_W-1:0]  col_w;
  logic              flag_w;
  logic              hit;
  logic              act_ok, rw_ok, is_rw, fwd;

  sdram_cmd_decode #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_dec (
    .cke_i (cke_i),
    .csn_i (csn_i),
    .rasn_i(rasn_i),
    .casn_i(casn_i),
    .wen_i (wen_i),
    .addr_i(addr_i),
    .kind_o(kind),
    .col_o (col_w),
    .flag_o(flag_w)
  );

  assign hit    = open_o[ba_i];
  assign is_rw  = (kind == K_RD) || (kind == K_WR);
  assign act_ok = (kind == K_ACT) && !hit;
  assign rw_ok  = is_rw && hit;
  assign fwd    = act_ok || rw_ok || (kind == K_PRE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    logic [ADDR_W-1:0] row_b;
    assign sel = (ba_i == BA_W'(b));

    sdram_bank_slot #(.ROW_W(ADDR_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_hit_i(act_ok && sel),
      .rw_hit_i (rw_ok && sel),
      .ap_i     (flag_w),
      .pre_hit_i((kind == K_PRE) && (flag_w || sel)),
      .done_i   (burst_done_i[b]),
      .row_i    (addr_i),
      .open_o   (open_o[b]),
      .row_o    (row_b)
    );
    assign rows_o[b*ADDR_W +: ADDR_W] = row_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_o       <= 1'b0;
      rd_o        <= 1'b0;
      wr_o        <= 1'b0;
      pre_o       <= 1'b0;
      unsup_o     <= 1'b0;
      proto_err_o <= 1'b0;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      auto_pre_o  <= 1'b0;
      pre_all_o   <= 1'b0;
    end else begin
      act_o       <= act_ok;
      rd_o        <= (kind == K_RD) && hit;
      wr_o        <= (kind == K_WR) && hit;
      pre_o       <= (kind == K_PRE);
      unsup_o     <= (kind == K_UNSUP);
      proto_err_o <= ((kind == K_ACT) && hit) || (is_rw && !hit);
      bank_o      <= fwd ? ba_i : '0;
      row_o       <= act_ok ? addr_i : '0;
      col_o       <= rw_ok ? col_w : '0;
      auto_pre_o  <= rw_ok && flag_w;
      pre_all_o   <= (kind == K_PRE) && flag_w;
    end
  end
endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk #(
  parameter int NUM_BANKS = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke_i,
  input logic                 csn_i,
  input logic                 act_o,
  input logic                 rd_o,
  input logic                 wr_o,
  input logic                 pre_o,
  input logic                 unsup_o,
  input logic                 proto_err_o,
  input logic                 pre_all_o,
  input logic [BA_W-1:0]      bank_o,
  input logic [NUM_BANKS-1:0] open_o
);
  logic [NUM_BANKS-1:0] open_d;
  logic any_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_d <= '0;
    else        open_d <= open_o;
  end

  assign any_pulse = act_o || rd_o || wr_o || pre_o || unsup_o || proto_err_o;

  // R12
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_o, rd_o, wr_o, pre_o, unsup_o, proto_err_o}));

  // R9
  rw_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o || wr_o) |-> open_d[bank_o]);

  // R2
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> (!open_d[bank_o] && open_o[bank_o]));

  // R4
  pre_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_o && !pre_all_o) |-> !open_o[bank_o]);

  // R5
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_o && pre_all_o) |-> (open_o == '0));

  // R6
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_i |=> !any_pulse);

  // R7
  cke_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_i |=> !any_pulse);
endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke_i      (cke_i),
  .csn_i      (csn_i),
  .act_o      (act_o),
  .rd_o       (rd_o),
  .wr_o       (wr_o),
  .pre_o      (pre_o),
  .unsup_o    (unsup_o),
  .proto_err_o(proto_err_o),
  .pre_all_o  (pre_all_o),
  .bank_o     (bank_o),
  .open_o     (open_o)
);

// File: tb/sdram_cmd_front_tb.sv
module sdram_cmd_front_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_i = 1'b1, csn_i = 1'b1, rasn_i = 1'b1, casn_i = 1'b1, wen_i = 1'b1;
  logic [1:0] ba_i = '0;
  logic [11:0] addr_i = '0;
  logic [3:0] burst_done_i = '0;
  logic act_o, rd_o, wr_o, pre_o, unsup_o, proto_err_o, auto_pre_o, pre_all_o;
  logic [1:0] bank_o;
  logic [11:0] row_o;
  logic [10:0] col_o;
  logic [3:0] open_o;
  logic [47:0] rows_o;

  int checks = 0;
  int errors = 0;

  logic [3:0]  m_open = '0;
  logic [3:0]  m_arm  = '0;
  logic [11:0] m_row [4] = '{default: '0};

  always #5 clk = ~clk;

  sdram_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .csn_i(csn_i),
    .rasn_i(rasn_i), .casn_i(casn_i), .wen_i(wen_i), .ba_i(ba_i),
    .addr_i(addr_i), .burst_done_i(burst_done_i),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o),
    .unsup_o(unsup_o), .proto_err_o(proto_err_o), .bank_o(bank_o),
    .row_o(row_o), .col_o(col_o), .auto_pre_o(auto_pre_o),
    .pre_all_o(pre_all_o), .open_o(open_o), .rows_o(rows_o)
  );

  function automatic logic [84:0] observed();
    return {act_o, rd_o, wr_o, pre_o, unsup_o, proto_err_o, bank_o, row_o,
            col_o, auto_pre_o, pre_all_o, open_o, rows_o};
  endfunction

  function automatic logic [47:0] model_rows();
    return {m_row[3], m_row[2], m_row[1], m_row[0]};
  endfunction

  task automatic compare(input string tag, input logic [84:0] exp);
    logic [84:0] got;
    got = observed();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check.
  task automatic issue(input string tag, input logic cke, input logic csn,
                       input logic [2:0] code, input logic [1:0] ba,
                       input logic [11:0] a, input logic [3:0] done);
    logic e_act, e_rd, e_wr, e_pre, e_uns, e_err, e_ap, e_all;
    logic [1:0] e_bank;
    logic [11:0] e_row;
    logic [10:0] e_col;
    logic live, hit;
    {e_act, e_rd, e_wr, e_pre, e_uns, e_err, e_ap, e_all} = '0;
    e_bank = '0; e_row = '0; e_col = '0;
    cke_i = cke; csn_i = csn; {rasn_i, casn_i, wen_i} = code;
    ba_i = ba; addr_i = a; burst_done_i = done;
    live = cke && !csn;
    hit = m_open[ba];
    if (live) begin
      case (code)
        3'b011: if (hit) e_err = 1'b1;
                else begin e_act = 1'b1; e_bank = ba; e_row = a; end
        3'b101, 3'b100:
          if (!hit) e_err = 1'b1;
          else begin
            e_rd = (code == 3'b101); e_wr = (code == 3'b100);
            e_bank = ba; e_col = {a[11], a[9:0]}; e_ap = a[10];
          end
        3'b010: begin e_pre = 1'b1; e_bank = ba; e_all = a[10]; end
        3'b111: ;
        default: e_uns = 1'b1;
      endcase
    end
    for (int b = 0; b < 4; b++) begin
      logic acth, rwh, preh, cls;
      acth = e_act && (ba == 2'(b));
      rwh  = (e_rd || e_wr) && (ba == 2'(b));
      preh = e_pre && (a[10] || ba == 2'(b));
      cls  = done[b] && m_arm[b];
      if (acth) begin m_open[b] = 1'b1; m_row[b] = a; end
      else if (preh || cls) m_open[b] = 1'b0;
      if (preh || acth) m_arm[b] = 1'b0;
      else if (rwh)     m_arm[b] = a[10];
      else if (cls)     m_arm[b] = 1'b0;
    end
    @(negedge clk);
    compare(tag, {e_act, e_rd, e_wr, e_pre, e_uns, e_err, e_bank, e_row,
                  e_col, e_ap, e_all, m_open, model_rows()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    compare("R1 reset", '0);
    rst_n = 1'b1;
    // R2 activate bank 1
    issue("R2", 1, 0, 3'b011, 2'd1, 12'hABC, 4'h0);
    // R3 read, A11 high, A10 low
    issue("R3", 1, 0, 3'b101, 2'd1, 12'h923, 4'h0);
    // R3 write with A10 high arms auto-precharge (R11)
    issue("R3", 1, 0, 3'b100, 2'd1, 12'h4FF, 4'h0);
    // R11 done on an unarmed bank: no effect
    issue("R11", 1, 0, 3'b111, 2'd0, 12'h000, 4'h1);
    // R11 done on armed bank 1 closes it
    issue("R11", 1, 0, 3'b111, 2'd0, 12'h000, 4'h2);
    // R9 read to closed bank
    issue("R9", 1, 0, 3'b101, 2'd2, 12'h010, 4'h0);
    issue("R2", 1, 0, 3'b011, 2'd2, 12'h155, 4'h0);
    // R10 second activate: error, row stays 155
    issue("R10", 1, 0, 3'b011, 2'd2, 12'h777, 4'h0);
    // R6 deselected activate ignored
    issue("R6", 1, 1, 3'b011, 2'd3, 12'h321, 4'h0);
    // R7 clock enable low: activate ignored
    issue("R7", 0, 0, 3'b011, 2'd3, 12'h321, 4'h0);
    // R8 unsupported codes
    issue("R8", 1, 0, 3'b000, 2'd0, 12'h000, 4'h0);
    issue("R8", 1, 0, 3'b001, 2'd0, 12'h000, 4'h0);
    issue("R8", 1, 0, 3'b110, 2'd0, 12'h000, 4'h0);
    // R4 single-bank precharge leaves bank 2 open
    issue("R2", 1, 0, 3'b011, 2'd0, 12'h0F0, 4'h0);
    issue("R4", 1, 0, 3'b010, 2'd0, 12'h000, 4'h0);
    // R5 precharge all with bank bits 3
    issue("R2", 1, 0, 3'b011, 2'd1, 12'h00F, 4'h0);
    issue("R5", 1, 0, 3'b010, 2'd3, 12'h400, 4'h0);
    // R6 armed auto-precharge completes while deselected
    issue("R2", 1, 0, 3'b011, 2'd3, 12'hC3C, 4'h0);
    issue("R11", 1, 0, 3'b101, 2'd3, 12'h401, 4'h0);
    issue("R6", 1, 1, 3'b111, 2'd0, 12'h000, 4'h8);
    // R12 random mix checked against the model
    for (int i = 0; i < 600; i++) begin
      logic [2:0] codes [8];
      logic [3:0] dn;
      codes = '{3'b011, 3'b101, 3'b100, 3'b010, 3'b111, 3'b000, 3'b001, 3'b110};
      dn = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      issue("R12", ($urandom % 10) != 0, ($urandom % 6) == 0,
            codes[(($urandom % 5) == 0) ? 4 + ($urandom % 4) : ($urandom % 4)],
            2'($urandom), 12'($urandom), dn);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule